// File: doc/BRIEF.md
# ALU Control Decoder

This block turns a two-bit operation class, supplied by the processor's main opcode decoder, into the three-bit control word that steers the ALU. The control word has one bit that inverts the second operand (for subtraction and set-less-than) and a two-bit result selector. The class names one of three things: address arithmetic for loads and stores, a comparison for branch-equal, or a register-register instruction. Only a register-register instruction needs the instruction's six-bit function field.

The decode happens in two stages. First, the class bits are reduced to one of three intents: force add, force subtract, or look at the function field. Second, only the low nibble of the function field is inspected, because the two upper bits carry no information for the supported operations. A nibble that matches no supported operation falls back to add. The block is purely combinational, so the control word follows its inputs within the same cycle.

Top module: `alu_ctrl_decoder`

## Requirements
- R1: With class `00`, the control word is `010` (add) for every function field value.
- R2: With class `01`, the control word is `110` (subtract) for every function field value.
- R3: With class `11`, the control word is `110`. Class bit 0 takes priority over class bit 1.
- R4: With class `10`, function low nibble `0000` gives `010` (add) and `0010` gives `110` (subtract).
- R5: With class `10`, function low nibble `0100` gives `000` (AND) and `0101` gives `001` (OR).
- R6: With class `10`, function low nibble `1010` gives `111` (set-less-than).
- R7: With class `10`, function bits 5 and 4 have no effect on the control word.
- R8: With class `10`, any low nibble other than `0000`, `0010`, `0100`, `0101` and `1010` gives `010`.
- R9: Control word bit 2 is the operand-invert flag and bits 1:0 are the result selector (`00` AND, `01` OR, `10` sum, `11` less-than). The word reflects the present inputs with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class_i | input | 2 | Operation class from the main decoder |
| funct_i | input | 6 | Function field of the instruction |
| alu_ctrl_o | output | 3 | {operand invert, result select[1:0]} |

## Verification
The load/store and branch classes are first driven with a handful of unrelated function fields. This shows that those classes ignore the field. The class `11` pattern separates a priority on bit 0 from a priority on bit 1. Each supported function code is then applied under all four settings of its upper two bits, which checks both the mapping and the don't-care on bits 5 and 4. Finally, every one of the 256 input combinations is compared with a table built from the requirements, which exposes any stray nibble decoded as something other than add.

// File: rtl/alu_ctrl_pkg.sv
package alu_ctrl_pkg;

    localparam int CLASS_W = 2;
    localparam int FUNCT_W = 6;
    localparam int KEY_W   = 4;
    localparam int SEL_W   = 2;
    localparam int CTRL_W  = SEL_W + 1;

    typedef enum logic [1:0] {
        INTENT_ADD   = 2'd0,
        INTENT_SUB   = 2'd1,
        INTENT_FIELD = 2'd2
    } intent_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } result_sel_e;

    typedef struct packed {
        logic        invert;
        result_sel_e sel;
    } alu_word_t;

    localparam logic [KEY_W-1:0] KEY_ADD = 4'b0000;
    localparam logic [KEY_W-1:0] KEY_SUB = 4'b0010;
    localparam logic [KEY_W-1:0] KEY_AND = 4'b0100;
    localparam logic [KEY_W-1:0] KEY_OR  = 4'b0101;
    localparam logic [KEY_W-1:0] KEY_SLT = 4'b1010;

    localparam alu_word_t WORD_ADD = '{invert: 1'b0, sel: SEL_SUM};
    localparam alu_word_t WORD_SUB = '{invert: 1'b1, sel: SEL_SUM};
    localparam alu_word_t WORD_AND = '{invert: 1'b0, sel: SEL_AND};
    localparam alu_word_t WORD_OR  = '{invert: 1'b0, sel: SEL_OR};
    localparam alu_word_t WORD_SLT = '{invert: 1'b1, sel: SEL_LESS};

endpackage

// File: rtl/alu_class_stage.sv
module alu_class_stage
    import alu_ctrl_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class_i,
    output intent_e            intent_o
);

    // Bit 0 wins over bit 1, so class 11 also forces subtract (R3).
    always_comb begin
        if (op_class_i[0]) begin
            intent_o = INTENT_SUB;
        end else if (op_class_i[1]) begin
            intent_o = INTENT_FIELD;
        end else begin
            intent_o = INTENT_ADD;
        end
    end

endmodule

// File: rtl/alu_field_stage.sv
module alu_field_stage
    import alu_ctrl_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    output alu_word_t        word_o
);

    always_comb begin
        unique case (key_i)
            KEY_ADD: word_o = WORD_ADD;
            KEY_SUB: word_o = WORD_SUB;
            KEY_AND: word_o = WORD_AND;
            KEY_OR:  word_o = WORD_OR;
            KEY_SLT: word_o = WORD_SLT;
            default: word_o = WORD_ADD;  // unknown code: safe add
        endcase
    end

endmodule

// File: rtl/alu_ctrl_decoder.sv
module alu_ctrl_decoder
    import alu_ctrl_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output logic [CTRL_W-1:0]  alu_ctrl_o
);

    intent_e   intent;
    alu_word_t field_word;
    alu_word_t out_word;

    alu_class_stage u_class (
        .op_class_i (op_class_i),
        .intent_o   (intent)
    );

    // Only the low nibble carries meaning; upper bits are don't-care.
    alu_field_stage u_field (
        .key_i  (funct_i[KEY_W-1:0]),
        .word_o (field_word)
    );

    always_comb begin
        unique case (intent)
            INTENT_SUB:   out_word = WORD_SUB;
            INTENT_FIELD: out_word = field_word;
            default:      out_word = WORD_ADD;
        endcase
    end

    assign alu_ctrl_o = out_word;

endmodule

// File: rtl/alu_ctrl_checker.sv
module alu_ctrl_checker
    import alu_ctrl_pkg::*;
(
    input logic [CLASS_W-1:0] op_class_i,
    input logic [FUNCT_W-1:0] funct_i,
    input logic [CTRL_W-1:0]  alu_ctrl_o
);

    always_comb begin
        if (!$isunknown({op_class_i, funct_i})) begin
            a_r1_mem_add: assert (op_class_i != 2'b00 || alu_ctrl_o == 3'b010)
                else $error("R1 violated");
            a_r3_bit0_sub: assert (!op_class_i[0] || alu_ctrl_o == 3'b110)
                else $error("R2/R3 violated");
            a_r6_less_than: assert (!(op_class_i == 2'b10 && funct_i[3:0] == 4'b1010)
                                    || alu_ctrl_o == 3'b111)
                else $error("R6 violated");
            a_r5_logic_plain: assert (alu_ctrl_o[1] || !alu_ctrl_o[2])
                else $error("R5 violated");
            a_r8_logic_only_field: assert (alu_ctrl_o[1] || op_class_i == 2'b10)
                else $error("R8 violated");
        end
    end

endmodule

bind alu_ctrl_decoder alu_ctrl_checker u_alu_ctrl_checker (
    .op_class_i (op_class_i),
    .funct_i    (funct_i),
    .alu_ctrl_o (alu_ctrl_o)
);

// File: tb/tb_alu_ctrl_decoder.sv
module tb_alu_ctrl_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_class;
    logic [5:0] funct;
    logic [2:0] ctrl;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    alu_ctrl_decoder dut (
        .op_class_i (op_class),
        .funct_i    (funct),
        .alu_ctrl_o (ctrl)
    );

    function automatic logic [2:0] expect_word(logic [1:0] c, logic [5:0] f);
        if (c == 2'b00) return 3'b010;
        if (c[0])       return 3'b110;
        case (f[3:0])
            4'b0000: return 3'b010;
            4'b0010: return 3'b110;
            4'b0100: return 3'b000;
            4'b0101: return 3'b001;
            4'b1010: return 3'b111;
            default: return 3'b010;
        endcase
    endfunction

    task automatic apply(input logic [1:0] c, input logic [5:0] f,
                         input logic [2:0] want, input string req);
        @(negedge clk);
        op_class = c;
        funct    = f;
        #1;
        n_vec++;
        if (ctrl !== want) begin
            n_bad++;
            $display("FAIL %s class=%b funct=%b got=%b expected=%b",
                     req, c, f, ctrl, want);
        end
    endtask

    task automatic t_reset_state();
        apply(2'b00, 6'b000000, 3'b010, "R1 reset-state");
    endtask

    task automatic t_mem_class();
        apply(2'b00, 6'b100010, 3'b010, "R1");
        apply(2'b00, 6'b101010, 3'b010, "R1");
        apply(2'b00, 6'b111111, 3'b010, "R1");
    endtask

    task automatic t_branch_class();
        apply(2'b01, 6'b100000, 3'b110, "R2");
        apply(2'b01, 6'b100100, 3'b110, "R2");
        apply(2'b01, 6'b000000, 3'b110, "R2");
    endtask

    task automatic t_unused_class();
        apply(2'b11, 6'b100100, 3'b110, "R3");
        apply(2'b11, 6'b101010, 3'b110, "R3");
    endtask

    task automatic t_field_codes();
        for (int hi = 0; hi < 4; hi++) begin
            apply(2'b10, {hi[1:0], 4'b0000}, 3'b010, "R4 R7");
            apply(2'b10, {hi[1:0], 4'b0010}, 3'b110, "R4 R7");
            apply(2'b10, {hi[1:0], 4'b0100}, 3'b000, "R5 R7");
            apply(2'b10, {hi[1:0], 4'b0101}, 3'b001, "R5 R7");
            apply(2'b10, {hi[1:0], 4'b1010}, 3'b111, "R6 R7 R9");
        end
    endtask

    task automatic t_unknown_codes();
        apply(2'b10, 6'b100111, 3'b010, "R8");
        apply(2'b10, 6'b101111, 3'b010, "R8");
        apply(2'b10, 6'b000001, 3'b010, "R8");
    endtask

    task automatic t_full_sweep();
        for (int v = 0; v < 256; v++) begin
            apply(v[7:6], v[5:0], expect_word(v[7:6], v[5:0]), "R9 sweep");
        end
    endtask

    initial begin
        op_class = 2'b00;
        funct    = 6'b000000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_mem_class();
        t_branch_class();
        t_unused_class();
        t_field_codes();
        t_unknown_codes();
        t_full_sweep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired got=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule